// File: doc/BRIEF.md
# Dual-Pin H-Bridge Coil PWM Channel

This block generates pulse-width modulated drive for the coils of a small motor. Each coil has two pins, a plus pin and a minus pin. Each pin is reported as a data bit with an output enable, so a released pin is simply one whose enable is low and that the pad ring leaves floating. All coils share one timer counter. The counter wraps either at a programmable period or, in fast mode, at 256 counts. Every wrap produces an overflow pulse.

Software writes each coil's 16-bit duty register over a plain register bus that has byte enables. That register is only a staging copy. The value that shapes the waveform sits in a working register, and the working register takes the staged value at the overflow pulse and at no other time. This lets software update coil 0 and then coil 1 within one counter period and have both new values start on the same count. A per-coil control field selects one of three pin arrangements: full bridge with a direction bit, half bridge driving one chosen pin, or both pins released.

Top module: `hbridge_coil_pwm`

## Requirements
- R1: While reset is asserted and after it ends, every duty, working duty and control register holds zero, fast mode is off and the period equals the RESET_PERIOD parameter. Each coil therefore shows its plus pin enabled and low and its minus pin released.
- R2: The working duty of a coil is reloaded only on an overflow pulse. A duty write made between two overflows leaves the pins following the old value until the next overflow.
- R3: If the duty register is written several times between two overflows, the working duty after the next overflow equals the last value written.
- R4: In normal mode, with period P, the counter steps 0, 1, …, P-1 and then returns to 0. The step from P-1 to 0 is the overflow. A period of 0 behaves like a period of 1, so every cycle is an overflow. The PWM level is high while the counter is below the effective duty.
- R5: A working duty of 0 gives a constant low PWM level. A working duty equal to or greater than P gives a constant high level in normal mode.
- R6: With fast mode on, the counter wraps after the count 255, and only bits 15:8 of the working duty are compared with the counter. A write with byte enables 2'b10 changes only bits 15:8 of the duty register.
- R7: Control mode 2'b10 (full bridge) enables both pins. With the sign bit at 0, the plus pin carries the PWM level and the minus pin is driven low. With the sign bit at 1, the minus pin carries the PWM level and the plus pin is driven low.
- R8: Control mode 2'b00 drives the plus pin with the PWM level and releases the minus pin. Mode 2'b01 drives the minus pin and releases the plus pin. In both of these modes the sign bit has no effect.
- R9: Control mode 2'b11 releases both pins. A released pin has its output enable low and its data bit at 0.
- R10: When the duty registers of coil 0 and then coil 1 are both written within one counter period, both new values take effect on the same overflow.
- R11: The register map is as follows. Address 0 holds the fast-mode bit in bit 0. Address 1 holds the period. Address 2+2c holds the duty of coil c. Address 3+2c holds the control of coil c, with the mode in bits 1:0 and the sign in bit 2. Byte enable bit b gates data byte b. Writes to the control, period and fast-mode registers take effect at the clock edge that captures them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe, captured at the rising clock edge |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_be | input | CNT_W/8 | Byte enables, one bit per data byte |
| coil_p_out | output | NUM_COILS | Plus pin data, one bit per coil |
| coil_p_oe | output | NUM_COILS | Plus pin output enable, one bit per coil |
| coil_m_out | output | NUM_COILS | Minus pin data, one bit per coil |
| coil_m_oe | output | NUM_COILS | Minus pin output enable, one bit per coil |

## Verification
The pins are combinational from the counter, the working duty and the control registers. A change caused at a rising edge is therefore visible at the very next falling edge. A control or period write lands one edge after the strobe is raised. A duty write becomes visible only after the overflow edge that follows it. The bench keeps its own model of the counter, the staged and working duties and the control fields, built from the requirements, and advances it on the same rising edges. It then compares all four pin signals of every coil at each falling edge across every scenario window. Separate counts of high cycles confirm the constant low and constant high cases.

// File: rtl/hbpwm_pkg.sv
package hbpwm_pkg;

  typedef enum logic [1:0] {
    DRV_HALF_PLUS  = 2'b00,
    DRV_HALF_MINUS = 2'b01,
    DRV_FULL       = 2'b10,
    DRV_OFF        = 2'b11
  } drive_mode_e;

  typedef struct packed {
    logic p_out;
    logic p_oe;
    logic m_out;
    logic m_oe;
  } pin_pair_t;

  // Route one PWM level onto the two pins of a coil.
  function automatic pin_pair_t map_pins(input drive_mode_e mode,
                                         input logic sign,
                                         input logic level);
    pin_pair_t r;
    r = '0;
    unique case (mode)
      DRV_HALF_PLUS: begin
        r.p_oe  = 1'b1;
        r.p_out = level;
      end
      DRV_HALF_MINUS: begin
        r.m_oe  = 1'b1;
        r.m_out = level;
      end
      DRV_FULL: begin
        r.p_oe = 1'b1;
        r.m_oe = 1'b1;
        if (sign) r.m_out = level;
        else      r.p_out = level;
      end
      default: r = '0;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/hbpwm_regs.sv
module hbpwm_regs #(
  parameter int unsigned NUM_COILS    = 2,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned RESET_PERIOD = 100
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             bus_we,
  input  logic [ADDR_W-1:0]                bus_addr,
  input  logic [CNT_W-1:0]                 bus_wdata,
  input  logic [CNT_W/8-1:0]               bus_be,
  output logic                             fast_q,
  output logic [CNT_W-1:0]                 period_q,
  output logic [NUM_COILS-1:0][CNT_W-1:0]  duty_q,
  output logic [NUM_COILS-1:0][1:0]        mode_q,
  output logic [NUM_COILS-1:0]             sign_q
);

  localparam int unsigned NBYTES          = CNT_W / 8;
  localparam logic [ADDR_W-1:0] A_GLOBAL  = '0;
  localparam logic [ADDR_W-1:0] A_PERIOD  = ADDR_W'(1);
  localparam int unsigned FIRST_COIL_ADDR = 2;

  function automatic logic [CNT_W-1:0] merge_bytes(input logic [CNT_W-1:0]  old_v,
                                                   input logic [CNT_W-1:0]  new_v,
                                                   input logic [NBYTES-1:0] be);
    logic [CNT_W-1:0] r;
    r = old_v;
    for (int b = 0; b < NBYTES; b++) begin
      if (be[b]) r[b*8 +: 8] = new_v[b*8 +: 8];
    end
    return r;
  endfunction

  wire wr_global = bus_we && (bus_addr == A_GLOBAL);
  wire wr_period = bus_we && (bus_addr == A_PERIOD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fast_q   <= 1'b0;
      period_q <= CNT_W'(RESET_PERIOD);
    end else begin
      if (wr_global && bus_be[0]) fast_q <= bus_wdata[0];
      if (wr_period) period_q <= merge_bytes(period_q, bus_wdata, bus_be);
    end
  end

  for (genvar c = 0; c < NUM_COILS; c++) begin : g_coil_regs
    localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(FIRST_COIL_ADDR + 2*c);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(FIRST_COIL_ADDR + 2*c + 1);

    wire wr_duty = bus_we && (bus_addr == A_DUTY);
    wire wr_ctrl = bus_we && (bus_addr == A_CTRL) && bus_be[0];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        duty_q[c] <= '0;
        mode_q[c] <= 2'b00;
        sign_q[c] <= 1'b0;
      end else begin
        if (wr_duty) duty_q[c] <= merge_bytes(duty_q[c], bus_wdata, bus_be);
        if (wr_ctrl) begin
          mode_q[c] <= bus_wdata[1:0];
          sign_q[c] <= bus_wdata[2];
        end
      end
    end

    // R11: a full-width duty write is captured whole.
    p_duty_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_DUTY && bus_be == '1) |=> duty_q[c] == $past(bus_wdata));

    // R6: a high-byte-only write keeps the low byte of the staged duty.
    p_high_byte_only_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we && bus_addr == A_DUTY && bus_be[0] == 1'b0) |=> duty_q[c][7:0] == $past(duty_q[c][7:0]));
  end

endmodule

// File: rtl/hbpwm_timebase.sv
module hbpwm_timebase #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FAST_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fast,
  input  logic [CNT_W-1:0] period,
  output logic [CNT_W-1:0] cnt,
  output logic             ovf
);

  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'((1 << FAST_W) - 1);

  // Last count before the wrap, for the current mode and period.
  function automatic logic [CNT_W-1:0] last_count(input logic f, input logic [CNT_W-1:0] p);
    if (f) return FAST_LAST;
    if (p == '0) return '0;
    return p - 1'b1;
  endfunction

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] wrap_at;

  assign wrap_at = last_count(fast, period);
  assign ovf     = (cnt_q >= wrap_at);
  assign cnt     = cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (ovf) cnt_q <= '0;
    else          cnt_q <= cnt_q + 1'b1;
  end

  // R4: the overflow returns the counter to zero.
  p_wrap_to_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> cnt == '0);

  // R4: between overflows the counter advances by one.
  p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> cnt == CNT_W'($past(cnt) + 1'b1));

  // R6: once inside the fast range, the counter stays inside it.
  p_fast_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (fast && $past(fast) && $past(cnt) <= FAST_LAST) |-> cnt <= FAST_LAST);

endmodule

// File: rtl/hbpwm_coil.sv
module hbpwm_coil #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FAST_W = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ovf,
  input  logic                  fast,
  input  logic [CNT_W-1:0]      cnt,
  input  logic [CNT_W-1:0]      duty,
  input  logic [1:0]            mode,
  input  logic                  sign,
  output hbpwm_pkg::pin_pair_t  pins,
  output logic                  level
);

  import hbpwm_pkg::*;

  // Duty value actually compared: full width, or only the top FAST_W bits.
  function automatic logic [CNT_W-1:0] eff_duty(input logic f, input logic [CNT_W-1:0] w);
    if (f) return {{(CNT_W-FAST_W){1'b0}}, w[CNT_W-1 -: FAST_W]};
    return w;
  endfunction

  logic [CNT_W-1:0] work_q;
  logic [CNT_W-1:0] cmp_val;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   work_q <= '0;
    else if (ovf) work_q <= duty;
  end

  assign cmp_val = eff_duty(fast, work_q);
  assign level   = (cnt < cmp_val);
  assign pins    = map_pins(drive_mode_e'(mode), sign, level);

  // R2: the working duty moves only on an overflow.
  p_hold_between_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf |=> $stable(work_q));

  // R3: the overflow loads the latest staged value.
  p_last_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> work_q == $past(duty));

endmodule

// File: rtl/hbridge_coil_pwm.sv
module hbridge_coil_pwm #(
  parameter int unsigned NUM_COILS    = 2,
  parameter int unsigned CNT_W        = 16,
  parameter int unsigned FAST_W       = 8,
  parameter int unsigned ADDR_W       = 4,
  parameter int unsigned RESET_PERIOD = 100
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  bus_we,
  input  logic [ADDR_W-1:0]     bus_addr,
  input  logic [CNT_W-1:0]      bus_wdata,
  input  logic [CNT_W/8-1:0]    bus_be,
  output logic [NUM_COILS-1:0]  coil_p_out,
  output logic [NUM_COILS-1:0]  coil_p_oe,
  output logic [NUM_COILS-1:0]  coil_m_out,
  output logic [NUM_COILS-1:0]  coil_m_oe
);

  import hbpwm_pkg::*;

  logic                            fast_q;
  logic [CNT_W-1:0]                period_q;
  logic [NUM_COILS-1:0][CNT_W-1:0] duty_q;
  logic [NUM_COILS-1:0][1:0]       mode_q;
  logic [NUM_COILS-1:0]            sign_q;
  logic [CNT_W-1:0]                cnt;
  logic                            ovf;
  logic [NUM_COILS-1:0]            level;

  hbpwm_regs #(
    .NUM_COILS(NUM_COILS), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .RESET_PERIOD(RESET_PERIOD)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .fast_q(fast_q), .period_q(period_q),
    .duty_q(duty_q), .mode_q(mode_q), .sign_q(sign_q)
  );

  hbpwm_timebase #(.CNT_W(CNT_W), .FAST_W(FAST_W)) u_timebase (
    .clk(clk), .rst_n(rst_n), .fast(fast_q), .period(period_q), .cnt(cnt), .ovf(ovf)
  );

  for (genvar c = 0; c < NUM_COILS; c++) begin : g_coil
    pin_pair_t pins;

    hbpwm_coil #(.CNT_W(CNT_W), .FAST_W(FAST_W)) u_coil (
      .clk(clk), .rst_n(rst_n), .ovf(ovf), .fast(fast_q), .cnt(cnt),
      .duty(duty_q[c]), .mode(mode_q[c]), .sign(sign_q[c]),
      .pins(pins), .level(level[c])
    );

    assign coil_p_out[c] = pins.p_out;
    assign coil_p_oe[c]  = pins.p_oe;
    assign coil_m_out[c] = pins.m_out;
    assign coil_m_oe[c]  = pins.m_oe;

    // R8: half bridge enables exactly one pin, and that pin follows the PWM level.
    p_half_one_pin_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[c][1] == 1'b0) |-> ($countones({coil_p_oe[c], coil_m_oe[c]}) == 1 &&
                                  (coil_p_out[c] | coil_m_out[c]) == level[c]));

    // R9: mode 11 releases both pins with their data low.
    p_both_released_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[c] == 2'b11) |-> !(coil_p_oe[c] || coil_m_oe[c] || coil_p_out[c] || coil_m_out[c]));

    // R7: full bridge enables both pins and never drives both high.
    p_full_both_driven_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_q[c] == 2'b10) |-> (coil_p_oe[c] && coil_m_oe[c] && !(coil_p_out[c] && coil_m_out[c])));
  end

endmodule

// File: tb/hbridge_coil_pwm_test.sv
module hbridge_coil_pwm_test;

  localparam int CLK_PERIOD = 10;
  localparam int NC = 2;
  localparam int WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [1:0] bus_be = '0;
  logic [NC-1:0] coil_p_out, coil_p_oe, coil_m_out, coil_m_oe;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hbridge_coil_pwm uut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .coil_p_out(coil_p_out),
    .coil_p_oe(coil_p_oe), .coil_m_out(coil_m_out), .coil_m_oe(coil_m_oe)
  );

  // Reference state, advanced from the requirements on each rising edge.
  logic [15:0] m_cnt, m_period;
  logic        m_fast;
  logic [15:0] m_duty [NC];
  logic [15:0] m_work [NC];
  logic [1:0]  m_mode [NC];
  logic        m_sign [NC];
  logic [15:0] m_last;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt <= '0; m_period <= 16'd100; m_fast <= 1'b0;
      for (int c = 0; c < NC; c++) begin
        m_duty[c] <= '0; m_work[c] <= '0; m_mode[c] <= 2'b00; m_sign[c] <= 1'b0;
      end
    end else begin
      if (m_fast) m_last = 16'd255;
      else if (m_period == 0) m_last = 16'd0;
      else m_last = m_period - 16'd1;
      if (m_cnt >= m_last) begin
        m_cnt <= '0;
        for (int c = 0; c < NC; c++) m_work[c] <= m_duty[c];
      end else begin
        m_cnt <= m_cnt + 16'd1;
      end
      if (bus_we) begin
        if (bus_addr == 4'd0 && bus_be[0]) m_fast <= bus_wdata[0];
        if (bus_addr == 4'd1) begin
          if (bus_be[1]) m_period[15:8] <= bus_wdata[15:8];
          if (bus_be[0]) m_period[7:0]  <= bus_wdata[7:0];
        end
        for (int c = 0; c < NC; c++) begin
          if (bus_addr == 4'(2 + 2*c)) begin
            if (bus_be[1]) m_duty[c][15:8] <= bus_wdata[15:8];
            if (bus_be[0]) m_duty[c][7:0]  <= bus_wdata[7:0];
          end
          if (bus_addr == 4'(3 + 2*c) && bus_be[0]) begin
            m_mode[c] <= bus_wdata[1:0];
            m_sign[c] <= bus_wdata[2];
          end
        end
      end
    end
  end

  function automatic logic ref_level(int c);
    logic [15:0] d;
    d = m_fast ? {8'h00, m_work[c][15:8]} : m_work[c];
    return m_cnt < d;
  endfunction

  // Expected {p_out, p_oe, m_out, m_oe}
  function automatic logic [3:0] ref_pins(int c);
    logic lv;
    lv = ref_level(c);
    if (m_mode[c] == 2'b00) return {lv, 1'b1, 1'b0, 1'b0};
    if (m_mode[c] == 2'b01) return {1'b0, 1'b0, lv, 1'b1};
    if (m_mode[c] == 2'b10) return m_sign[c] ? {1'b0, 1'b1, lv, 1'b1} : {lv, 1'b1, 1'b0, 1'b1};
    return 4'b0000;
  endfunction

  function automatic logic [3:0] dut_pins(int c);
    return {coil_p_out[c], coil_p_oe[c], coil_m_out[c], coil_m_oe[c]};
  endfunction

  task automatic check_eq(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Compare every coil against the reference at each falling edge.
  task automatic check_window(int n, string req);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      for (int c = 0; c < NC; c++)
        check_eq(req, $sformatf("coil%0d pins cycle %0d", c, i), 32'(dut_pins(c)), 32'(ref_pins(c)));
    end
  endtask

  task automatic bus_write(logic [3:0] a, logic [15:0] d, logic [1:0] be);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_we = 1'b0; bus_be = 2'b00;
  endtask

  task automatic count_high(int c, int n, output int hits);
    hits = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (coil_p_out[c]) hits++;
    end
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    for (int c = 0; c < NC; c++)
      check_eq("R1", $sformatf("coil%0d pins in reset", c), 32'(dut_pins(c)), 32'(4'b0100));
    rst_n = 1'b1;
    check_window(4, "R1");
  endtask

  task automatic test_normal_pwm();
    bus_write(4'd1, 16'd10, 2'b11);           // R11 period register
    bus_write(4'd2, 16'd4, 2'b11);
    bus_write(4'd4, 16'd7, 2'b11);
    check_window(40, "R4");
  endtask

  task automatic test_hold_until_overflow();
    check_window(3, "R2");
    bus_write(4'd2, 16'd8, 2'b11);
    check_window(25, "R2");
  endtask

  task automatic test_last_write_wins();
    bus_write(4'd2, 16'd1, 2'b11);
    bus_write(4'd2, 16'd9, 2'b11);
    bus_write(4'd2, 16'd5, 2'b11);
    check_window(25, "R3");
  endtask

  task automatic test_extremes();
    int hits;
    bus_write(4'd2, 16'd0, 2'b11);
    bus_write(4'd4, 16'hFFFF, 2'b11);
    check_window(12, "R5");
    count_high(0, 20, hits);
    check_eq("R5", "coil0 high cycles with duty 0", 32'(hits), 32'd0);
    count_high(1, 20, hits);
    check_eq("R5", "coil1 high cycles with duty >= period", 32'(hits), 32'd20);
  endtask

  task automatic test_period_zero();
    bus_write(4'd1, 16'd0, 2'b11);
    bus_write(4'd2, 16'd1, 2'b11);
    check_window(10, "R4");
    bus_write(4'd1, 16'd10, 2'b11);
    bus_write(4'd2, 16'd3, 2'b11);
    check_window(12, "R4");
  endtask

  task automatic test_full_bridge();
    bus_write(4'd3, 16'h0002, 2'b01);         // R7 mode 10, sign 0
    check_window(22, "R7");
    bus_write(4'd3, 16'h0006, 2'b01);         // R7 mode 10, sign 1
    check_window(22, "R7");
  endtask

  task automatic test_half_bridge();
    bus_write(4'd3, 16'h0001, 2'b01);         // R8 mode 01, sign 0
    check_window(12, "R8");
    bus_write(4'd3, 16'h0005, 2'b01);         // R8 mode 01, sign 1
    check_window(12, "R8");
    bus_write(4'd3, 16'h0004, 2'b01);         // R8 mode 00, sign 1
    check_window(12, "R8");
  endtask

  task automatic test_released();
    bus_write(4'd5, 16'h0003, 2'b01);         // R9 coil1 both released
    check_window(15, "R9");
    bus_write(4'd5, 16'h0000, 2'b01);
    bus_write(4'd3, 16'h0000, 2'b01);
    check_window(3, "R11");
  endtask

  task automatic test_fast_mode();
    bus_write(4'd2, 16'h40AA, 2'b10);         // R6 high byte only
    bus_write(4'd4, 16'h20FF, 2'b11);
    bus_write(4'd0, 16'h0001, 2'b01);
    check_window(600, "R6");
    bus_write(4'd0, 16'h0000, 2'b01);
    check_window(15, "R6");
  endtask

  task automatic test_pair_update();
    bus_write(4'd1, 16'd20, 2'b11);
    check_window(25, "R10");
    bus_write(4'd2, 16'd6, 2'b11);
    bus_write(4'd4, 16'd15, 2'b11);
    check_window(45, "R10");
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1-R11 actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    test_reset();
    test_normal_pwm();
    test_hold_until_overflow();
    test_last_write_wins();
    test_extremes();
    test_period_zero();
    test_full_bridge();
    test_half_bridge();
    test_released();
    test_fast_mode();
    test_pair_update();
    done = 1'b1;
    finish_run();
  end

endmodule